// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by an integer ratio chosen from 2400 to 2483 in steps of one. It is meant to sit in the feedback path of a phase-locked loop, where one step of the ratio equals one step of the reference frequency. A behavioural prescaler divides the fast clock by 47 or by 48. Two 6-bit down counters sit behind it. The program counter sets how many prescaler periods make up one output period. The swallow counter sets how many of those periods use the shorter modulus. The ratio of one output period is therefore 48·P − S.

The program value is partly hard-wired: its three upper bits are fixed, so only the values 51 and 52 can be reached. The swallow value may range from 0 to 48. Both values are taken only at the instant the program counter runs out and a new output period begins. A configuration that cannot give a ratio inside the legal range is flagged for the whole period it governs, and a safe ratio is used in its place. While the swallow counter sits at zero, it holds still until the next reload.

Top module: `pulse_swallow_div`

## Requirements
- R1: For a legal configuration, every output period lasts exactly 48·P − S input clocks, covering 2400 (P=51, S=48), 2448 (P=51, S=0), 2449 (P=52, S=47) and 2483 (P=52, S=13).
- R2: The three upper bits of `p_code` are ignored and treated as binary 110. The low three bits select the program value: 011 gives P=51 and 100 gives P=52.
- R3: Within a period, `mod_ctl` is low (prescaler divides by 47) for exactly 47·S input clocks starting at the period's first cycle, and high (divides by 48) for the rest. With S=0 it stays high all period.
- R4: Once the swallow counter reaches zero, it stays at zero until the next reload, so `mod_ctl` does not fall again within the period.
- R5: `p_code` and `s_code` are sampled only at the clock edge that ends a period. A change in the middle of a period leaves that period's length, duty and error flag unchanged.
- R6: `div_out` rises in the first cycle of each period and stays high for the first 23 prescaler periods. This is 47·min(S,23) + 48·(23 − min(S,23)) input clocks, a duty cycle near 45%.
- R7: A configuration is invalid when the low bits of `p_code` are neither 011 nor 100, when S > 48, or when 48·P − S lies outside 2400..2483. For an invalid configuration, `cfg_err` is high for that whole period, S is replaced by 48, and an unusable P code is replaced by 52.
- R8: Reset is synchronous and active high. While it is held, the counters are loaded from the inputs, `div_out` is 1, `mod_ctl` equals (S = 0), and `cfg_err` reflects the input configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| p_code | input | 6 | Program value; only bits 2:0 are used |
| s_code | input | 6 | Swallow value, 0 to 48 |
| div_out | output | 1 | Divided clock, one rising edge per period |
| mod_ctl | output | 1 | Modulus control: 0 selects divide-by-47, 1 selects divide-by-48 |
| cfg_err | output | 1 | High for a period whose configuration was invalid and clamped |

## Verification
All results of a new configuration appear one register stage after the reload edge. In the first cycle of the new period, `div_out` goes high, `cfg_err` takes its new value, and `mod_ctl` settles for the swallow phase. After that, the period length, high time and swallow time are only known when the next rising edge of `div_out` arrives. The bench samples every output on the falling clock edge and counts samples from one rise of `div_out` to the next. It compares each completed period against an expectation queued at the start of that period, so every comparison is made exactly when its count is complete. When inputs are changed mid-period, the driver queues the old configuration's expectation for that period and the new one for the following period.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;

    localparam int CW           = 6;
    localparam int PRE_BASE     = 47;
    localparam int S_MAX        = 48;
    localparam int RATIO_MIN    = 2400;
    localparam int RATIO_MAX    = 2483;
    localparam int HIGH_PERIODS = 23;
    localparam int P_LOW_VAL    = 51;
    localparam int P_HIGH_VAL   = 52;
    localparam int FIXED_BITS   = 3;
    localparam logic [FIXED_BITS-1:0] P_TOP = 3'b110;

    typedef struct packed {
        logic [CW-1:0] p;
        logic [CW-1:0] s;
        logic          bad;
    } ratio_cfg_t;

    // Resolve raw input codes into the values a period will actually use.
    function automatic ratio_cfg_t resolve_cfg(input logic [CW-1:0] p_raw,
                                               input logic [CW-1:0] s_raw);
        ratio_cfg_t    r;
        logic [CW-1:0] p_fix;
        logic          p_ok;
        int            ratio;
        p_fix = {P_TOP, p_raw[CW-FIXED_BITS-1:0]};
        p_ok  = (int'(p_fix) == P_LOW_VAL) || (int'(p_fix) == P_HIGH_VAL);
        r.p   = p_ok ? p_fix : CW'(P_HIGH_VAL);
        ratio = (PRE_BASE + 1) * int'(r.p) - int'(s_raw);
        r.bad = !p_ok || (int'(s_raw) > S_MAX) || (ratio < RATIO_MIN) || (ratio > RATIO_MAX);
        r.s   = r.bad ? CW'(S_MAX) : s_raw;
        return r;
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler #(
    parameter int BASE = 47,
    parameter int W    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_hi,
    output logic tc
);
    localparam logic [W-1:0] LAST_LO = W'(BASE - 1);
    localparam logic [W-1:0] LAST_HI = W'(BASE);

    logic [W-1:0] cnt;

    assign tc = (cnt == (mod_hi ? LAST_HI : LAST_LO));

    always_ff @(posedge clk) begin
        if (rst || tc) cnt <= '0;
        else           cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/psd_downcnt.sv
`timescale 1ns/1ps
module psd_downcnt #(
    parameter int W            = 6,
    parameter bit HOLD_AT_ZERO = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt
);
    generate
        if (HOLD_AT_ZERO) begin : g_hold
            always_ff @(posedge clk) begin
                if (rst || load)             cnt <= load_val;
                else if (step && cnt != '0)  cnt <= cnt - W'(1);
            end
        end else begin : g_free
            always_ff @(posedge clk) begin
                if (rst || load) cnt <= load_val;
                else if (step)   cnt <= cnt - W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int BASE   = PRE_BASE,
    parameter int HIGH_N = HIGH_PERIODS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] p_code,
    input  logic [CW-1:0] s_code,
    output logic          div_out,
    output logic          mod_ctl,
    output logic          cfg_err
);
    localparam int PW = $clog2(BASE + 1);

    ratio_cfg_t    nxt;
    logic [CW-1:0] cur_p;
    logic          cur_bad;
    logic          pre_tc;
    logic          reload;
    logic          s_done;
    logic [CW-1:0] p_cnt;
    logic [CW-1:0] s_cnt;
    logic [CW-1:0] elapsed;

    assign nxt    = resolve_cfg(p_code, s_code);
    assign s_done = (s_cnt == '0);
    assign reload = pre_tc && (p_cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            cur_p   <= nxt.p;
            cur_bad <= nxt.bad;
        end
    end

    psd_prescaler #(.BASE(BASE), .W(PW)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .mod_hi (s_done),
        .tc     (pre_tc)
    );

    psd_downcnt #(.W(CW), .HOLD_AT_ZERO(1'b0)) u_pcnt (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (nxt.p),
        .step     (pre_tc),
        .cnt      (p_cnt)
    );

    psd_downcnt #(.W(CW), .HOLD_AT_ZERO(1'b1)) u_scnt (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (nxt.s),
        .step     (pre_tc),
        .cnt      (s_cnt)
    );

    assign elapsed = cur_p - p_cnt;
    assign div_out = (elapsed < CW'(HIGH_N));
    assign mod_ctl = s_done;
    assign cfg_err = cur_bad;
endmodule

// File: rtl/psd_chk.sv
`timescale 1ns/1ps
module psd_chk
    import psd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          reload,
    input logic [CW-1:0] p_cnt,
    input logic [CW-1:0] s_cnt,
    input logic [CW-1:0] cur_p,
    input logic          div_out,
    input logic          mod_ctl,
    input logic          cfg_err
);
    // R4
    s_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_cnt == '0 && !reload) |=> (s_cnt == '0));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> ($stable(cur_p) && $stable(cfg_err)));

    // R6
    div_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(div_out) |-> $past(reload));

    // R3
    mod_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_ctl) |-> $past(reload));

    // R7
    clamp_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> (!cfg_err || s_cnt == CW'(S_MAX)));

    // R2
    p_range_chk: assert property (@(posedge clk) disable iff (rst)
        (p_cnt != '0) && (p_cnt <= cur_p) &&
        (int'(cur_p) == P_LOW_VAL || int'(cur_p) == P_HIGH_VAL));
endmodule

bind pulse_swallow_div psd_chk u_psd_chk (
    .clk     (clk),
    .rst     (rst),
    .reload  (reload),
    .p_cnt   (p_cnt),
    .s_cnt   (s_cnt),
    .cur_p   (cur_p),
    .div_out (div_out),
    .mod_ctl (mod_ctl),
    .cfg_err (cfg_err)
);

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
module test_pulse_swallow_div;

    typedef struct {
        int    ratio;
        int    hi;
        int    lo;
        bit    err;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] p_code = 6'd51;
    logic [5:0] s_code = 6'd0;
    logic       div_out, mod_ctl, cfg_err;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    exp_t q[$];
    exp_t cur;
    event rise_ev;

    int   cnt = 0, hi = 0, lo = 0;
    bit   armed = 0, prev_div = 1'b1, err_seen = 0;

    always #2 clk = ~clk;

    pulse_swallow_div i_pulse_swallow_div (
        .clk     (clk),
        .rst     (rst),
        .p_code  (p_code),
        .s_code  (s_code),
        .div_out (div_out),
        .mod_ctl (mod_ctl),
        .cfg_err (cfg_err)
    );

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [5:0] p, input logic [5:0] s, input string tag);
        exp_t m;
        int   pv, sv, r, k;
        bit   okp, bd;
        okp = (p[2:0] == 3'b011) || (p[2:0] == 3'b100);
        pv  = (p[2:0] == 3'b011) ? 51 : 52;
        sv  = int'(s);
        r   = 48 * pv - sv;
        bd  = !okp || sv > 48 || r < 2400 || r > 2483;
        if (bd) sv = 48;
        k       = (sv < 23) ? sv : 23;
        m.ratio = 48 * pv - sv;
        m.hi    = 47 * k + 48 * (23 - k);
        m.lo    = 47 * sv;
        m.err   = bd;
        m.tag   = tag;
        return m;
    endfunction

    // monitor: measure each period between rises of div_out
    always @(negedge clk) begin
        if (!rst) begin
            if (div_out && !prev_div) begin
                if (armed && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.tag, " R1 ratio"}, cnt, e.ratio);
                    chk({e.tag, " R6 high time"}, hi, e.hi);
                    chk({e.tag, " R3/R4 swallow time"}, lo, e.lo);
                    chk({e.tag, " R7 err"}, int'(err_seen), int'(e.err));
                end
                armed    = 1;
                cnt      = 0;
                hi       = 0;
                lo       = 0;
                err_seen = cfg_err;
                -> rise_ev;
            end
            cnt++;
            hi += int'(div_out);
            lo += int'(!mod_ctl);
        end
        prev_div = div_out;
    end

    // driver: change inputs mid-period, then expect old config now and new config after
    task automatic apply(input logic [5:0] p, input logic [5:0] s, input int n, input string tag);
        exp_t old_e;
        @(rise_ev);
        repeat (200) @(negedge clk);
        p_code = p;
        s_code = s;
        old_e     = cur;
        old_e.tag = {cur.tag, " R5 mid-change"};
        q.push_back(old_e);
        cur = model(p, s, tag);
        for (int k = 0; k < n; k++) begin
            @(rise_ev);
            q.push_back(cur);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R8 div_out in reset", int'(div_out), 1);
        chk("R8 mod_ctl in reset", int'(mod_ctl), 1);
        chk("R8 cfg_err in reset", int'(cfg_err), 0);
        s_code = 6'd60;
        repeat (2) @(negedge clk);
        chk("R8 cfg_err in reset bad S", int'(cfg_err), 1);
        chk("R8 mod_ctl in reset clamped S", int'(mod_ctl), 0);
        s_code = 6'd0;
        repeat (2) @(negedge clk);
        cur = model(6'd51, 6'd0, "R1 init");
        rst = 1'b0;

        apply(6'd51, 6'd48, 2, "R1 2400");
        apply(6'd51, 6'd0,  2, "R1 R3 2448 S0");
        apply(6'd52, 6'd47, 2, "R1 2449");
        apply(6'd52, 6'd13, 2, "R1 2483");
        apply(6'd51, 6'd23, 2, "R6 S23");
        apply(6'd52, 6'd60, 2, "R7 S over");
        apply(6'd52, 6'd5,  2, "R7 ratio high");
        apply(6'b000011, 6'd1,  2, "R2 top bits 000");
        apply(6'b111111, 6'd10, 2, "R7 bad P code");
        apply(6'b001100, 6'd20, 2, "R2 top bits 001");
        @(rise_ev);
        chk("R1 queue drained", q.size(), 0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule